// File: doc/BRIEF.md
# Dual-Mode Saturating Error Counter

This block counts error events in an E1 receive path and holds the result for a processor to read. It has two count sources. In signalling mode the source is the Sa6 group of each CRC submultiframe: the counter steps by one whenever that group's four bits match one of two alarm patterns. This mode works only while CRC multiframe format is in use and multiframe alignment holds. In PRBS mode the source is the bit-error strobe of a pseudo-random test-pattern checker, and it counts only while that checker is in lock. A test input forces one count per submultiframe, so software can exercise the path without real errors. The count saturates at all ones and never wraps.

A 16-bit holding buffer is presented on a byte-wide read port. The buffer works in one of two ways:

- **Manual mode.** The buffer follows the counter until software raises a snapshot request. The rising edge of that request freezes the buffer and clears the counter. The request drops again when software reads the high byte.
- **Per-second mode.** Each one-second tick copies the counter into the buffer, clears the counter and raises an interrupt flag. A high-byte read clears the flag.

If a clear and an event fall in the same cycle, the event is kept in the freshly cleared counter.

Top module: `err_event_counter`

## Requirements
- R1: After reset the counter, the buffer, the snapshot request and the interrupt flag are all zero.
- R2: The counter increments once per submultiframe strobe in signalling mode (`cfg_prbs_mode`=0). This requires `cfg_crc_mf`=1 and `mf_unlocked`=0, and the nibble must equal 4'b0001 or 4'b0011. Bit 3 of `sa6_nibble` is the first-received bit. The other 14 nibble values do not count.
- R3: In signalling mode a strobe does not count while `mf_unlocked`=1 or while `cfg_crc_mf`=0, whatever the nibble.
- R4: In PRBS mode (`cfg_prbs_mode`=1) the counter increments in every cycle in which `prbs_err`=1 and `prbs_locked`=1. It does not count while `prbs_locked`=0. Each mode ignores the other mode's event input.
- R5: While `alarm_sim`=1, every submultiframe strobe increments the counter once, regardless of nibble, mode and lock status.
- R6: The counter stops at 16'hFFFF and never wraps.
- R7: In manual mode (`cfg_sec_latch`=0), with no snapshot pending, the buffer equals the counter one cycle later.
- R8: In manual mode, writing 1 to the snapshot request while it is 0 does two things at the next edge. It loads the buffer with the counter and clears the counter. The buffer then stays frozen while the request remains 1.
- R9: A read of the high byte (`rd_en`=1, `rd_addr`=1) clears the snapshot request, after which the buffer resumes tracking. A low-byte read leaves the request set.
- R10: In per-second mode, each `sec_tick` loads the buffer with the counter and clears the counter. Between ticks the buffer holds its value.
- R11: In per-second mode each tick sets `sec_irq`. A high-byte read clears it.
- R12: An event in the same cycle as a clear leaves the counter at 1, and the buffer receives the pre-clear value.
- R13: `rd_data` shows buffer bits 7:0 when `rd_addr`=0 and bits 15:8 when `rd_addr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prbs_mode | input | 1 | 0: count Sa6 patterns, 1: count PRBS bit errors |
| cfg_sec_latch | input | 1 | 0: manual snapshot, 1: per-second latch |
| cfg_crc_mf | input | 1 | 1: CRC multiframe format, 0: doubleframe |
| mf_unlocked | input | 1 | Loss of multiframe alignment |
| prbs_locked | input | 1 | PRBS checker in sync |
| alarm_sim | input | 1 | Alarm simulation enable |
| smf_strobe | input | 1 | One-cycle pulse per received submultiframe |
| sa6_nibble | input | 4 | Sa6 group of that submultiframe, bit 3 first received |
| prbs_err | input | 1 | PRBS bit-error strobe |
| sec_tick | input | 1 | One-second pulse |
| ctl_wr | input | 1 | Write strobe for the snapshot request bit |
| ctl_wdata | input | 1 | Value written to the snapshot request bit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0: low byte, 1: high byte |
| rd_data | output | 8 | Selected buffer byte |
| snap_req | output | 1 | Snapshot request bit |
| sec_irq | output | 1 | Per-second latch interrupt flag |

## Verification
Timing of each result, counted from the clock edge at which a stimulus is applied:

| Result | Due |
|---|---|
| Counter change from an event | at that edge |
| Buffer in tracking mode | one edge later |
| Snapshot capture or per-second latch (buffer and counter) | at that edge |
| `snap_req` and `sec_irq` | at the edge that applies the write, tick or high-byte read |
| `rd_data` | combinationally from the buffer |

The bench drives inputs on falling edges and holds each pulse for exactly one rising edge. It then waits at least two more falling edges before it samples `rd_data` or the flags, so every result it checks has settled. The bench observes the counter only through the buffer. It therefore checks a clear by watching the buffer after tracking resumes, or after the next tick.

// File: rtl/err_event_counter.sv
module err_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_prbs_mode,
  input  logic       cfg_sec_latch,
  input  logic       cfg_crc_mf,
  input  logic       mf_unlocked,
  input  logic       prbs_locked,
  input  logic       alarm_sim,
  input  logic       smf_strobe,
  input  logic [3:0] sa6_nibble,
  input  logic       prbs_err,
  input  logic       sec_tick,
  input  logic       ctl_wr,
  input  logic       ctl_wdata,
  input  logic       rd_en,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       snap_req,
  output logic       sec_irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, buf_q;
  logic             req_q, irq_q;

  logic sa6_hit, sa6_inc, prbs_inc, inc;
  logic hi_rd, req_rise, clr_cnt;

  assign sa6_hit  = (sa6_nibble == 4'b0001) || (sa6_nibble == 4'b0011);
  assign sa6_inc  = !cfg_prbs_mode && cfg_crc_mf && !mf_unlocked && smf_strobe && sa6_hit;
  assign prbs_inc = cfg_prbs_mode && prbs_locked && prbs_err;
  assign inc      = sa6_inc || prbs_inc || (alarm_sim && smf_strobe);

  assign hi_rd    = rd_en && rd_addr;
  assign req_rise = ctl_wr && ctl_wdata && !req_q;
  assign clr_cnt  = cfg_sec_latch ? sec_tick : req_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr_cnt)
      cnt_q <= inc ? CNT_W'(1) : '0;
    else if (inc && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      buf_q <= '0;
    else if (cfg_sec_latch) begin
      if (sec_tick)
        buf_q <= cnt_q;
    end else if (req_rise || !req_q)
      buf_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      req_q <= 1'b0;
    else if (ctl_wr)
      req_q <= ctl_wdata;
    else if (hi_rd)
      req_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else if (cfg_sec_latch && sec_tick)
      irq_q <= 1'b1;
    else if (hi_rd)
      irq_q <= 1'b0;
  end

  assign rd_data  = rd_addr ? buf_q[15:8] : buf_q[7:0];
  assign snap_req = req_q;
  assign sec_irq  = irq_q;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_cnt) |=> cnt_q == CNT_MAX);

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cnt |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  p_buf_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sec_latch && snap_req) |=> $stable(buf_q));

  p_req_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !ctl_wr) |=> !snap_req);

  p_tick_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sec_latch && sec_tick && !inc) |=> cnt_q == '0);

  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sec_latch && sec_tick) |=> sec_irq);

  p_clear_keeps_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cnt && inc) |=> cnt_q == CNT_W'(1));
endmodule

// File: tb/err_event_counter_tb.sv
module err_event_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_prbs_mode = 0, cfg_sec_latch = 0, cfg_crc_mf = 1, mf_unlocked = 0;
  logic prbs_locked = 0, alarm_sim = 0, smf_strobe = 0, prbs_err = 0, sec_tick = 0;
  logic [3:0] sa6_nibble = '0;
  logic ctl_wr = 0, ctl_wdata = 0, rd_en = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic snap_req, sec_irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int exp_cnt = 0;
  logic [15:0] bv;

  always #10 clk = ~clk;

  err_event_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_prbs_mode(cfg_prbs_mode), .cfg_sec_latch(cfg_sec_latch),
    .cfg_crc_mf(cfg_crc_mf), .mf_unlocked(mf_unlocked), .prbs_locked(prbs_locked),
    .alarm_sim(alarm_sim), .smf_strobe(smf_strobe), .sa6_nibble(sa6_nibble),
    .prbs_err(prbs_err), .sec_tick(sec_tick), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .snap_req(snap_req), .sec_irq(sec_irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic get_buf(output logic [15:0] v);
    rd_addr = 1'b0; #1 v[7:0] = rd_data;
    rd_addr = 1'b1; #1 v[15:8] = rd_data;
    rd_addr = 1'b0;
  endtask

  task automatic smf(input logic [3:0] nib);
    @(negedge clk) smf_strobe = 1; sa6_nibble = nib;
    @(negedge clk) smf_strobe = 0;
  endtask

  task automatic perr(input int n);
    @(negedge clk) prbs_err = 1;
    repeat (n) @(negedge clk);
    prbs_err = 0;
  endtask

  task automatic snap();
    @(negedge clk) ctl_wr = 1; ctl_wdata = 1;
    @(negedge clk) ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic hi_read();
    @(negedge clk) rd_en = 1; rd_addr = 1;
    @(negedge clk) rd_en = 0; rd_addr = 0;
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1;
    @(negedge clk) sec_tick = 0;
  endtask

  task automatic zero_counter();
    snap(); hi_read(); settle(); exp_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    get_buf(bv);
    chk("R1 buffer after reset", bv, 0);
    chk("R1 snap_req after reset", snap_req, 0);
    chk("R1 sec_irq after reset", sec_irq, 0);
    rst_n = 1'b1;
    settle();

    for (int n = 0; n < 16; n++) begin
      smf(n[3:0]);
      if (n == 1 || n == 3) exp_cnt++;
      settle();
      get_buf(bv);
      chk($sformatf("R2 R7 nibble %0d", n), bv, exp_cnt);
    end

    mf_unlocked = 1; smf(4'b0001); smf(4'b0011); mf_unlocked = 0;
    cfg_crc_mf = 0; smf(4'b0001); smf(4'b0011); cfg_crc_mf = 1;
    settle(); get_buf(bv);
    chk("R3 gated Sa6 strobes", bv, exp_cnt);

    perr(2); settle(); get_buf(bv);
    chk("R4 prbs_err ignored in Sa6 mode", bv, exp_cnt);
    cfg_prbs_mode = 1; prbs_locked = 1;
    perr(5); exp_cnt += 5; settle(); get_buf(bv);
    chk("R4 PRBS errors counted", bv, exp_cnt);
    prbs_locked = 0; perr(3); smf(4'b0001); settle(); get_buf(bv);
    chk("R4 unlocked errors and Sa6 strobe ignored", bv, exp_cnt);

    alarm_sim = 1; mf_unlocked = 1;
    smf(4'hF); smf(4'h0); smf(4'h1); smf(4'h8); exp_cnt += 4;
    alarm_sim = 0; mf_unlocked = 0; settle(); get_buf(bv);
    chk("R5 alarm simulation per submultiframe", bv, exp_cnt);

    prbs_locked = 1;
    snap(); settle();
    chk("R8 snap_req set", snap_req, 1);
    get_buf(bv); chk("R8 snapshot value", bv, exp_cnt);
    perr(3); settle(); get_buf(bv);
    chk("R8 buffer frozen under events", bv, exp_cnt);
    @(negedge clk) rd_en = 1; rd_addr = 0;
    @(negedge clk) rd_en = 0;
    chk("R9 low-byte read keeps request", snap_req, 1);
    hi_read(); settle();
    chk("R9 high-byte read clears request", snap_req, 0);
    get_buf(bv); chk("R8 R9 counter cleared then tracks", bv, 3);

    exp_cnt = 3;
    @(negedge clk) prbs_err = 1; ctl_wr = 1; ctl_wdata = 1;
    @(negedge clk) prbs_err = 0; ctl_wr = 0; ctl_wdata = 0;
    settle(); get_buf(bv);
    chk("R12 pre-clear value captured", bv, 3);
    hi_read(); settle(); get_buf(bv);
    chk("R12 coincident event kept", bv, 1);

    zero_counter();
    perr(300); settle();
    rd_addr = 0; #1 chk("R13 low byte", rd_data, 300 & 255);
    rd_addr = 1; #1 chk("R13 high byte", rd_data, 300 >> 8);
    rd_addr = 0;
    perr(65300); settle(); get_buf(bv);
    chk("R6 saturation", bv, 16'hFFFF);
    perr(10); settle(); get_buf(bv);
    chk("R6 no wrap", bv, 16'hFFFF);

    cfg_sec_latch = 1; settle();
    tick(); settle(); get_buf(bv);
    chk("R10 tick latches", bv, 16'hFFFF);
    chk("R11 irq set", sec_irq, 1);
    perr(7); settle(); get_buf(bv);
    chk("R10 buffer holds between ticks", bv, 16'hFFFF);
    hi_read(); settle();
    chk("R11 irq cleared by high read", sec_irq, 0);
    tick(); settle(); get_buf(bv);
    chk("R10 counter was cleared by tick", bv, 7);
    @(negedge clk) prbs_err = 1; sec_tick = 1;
    @(negedge clk) prbs_err = 0; sec_tick = 0;
    settle(); tick(); settle(); get_buf(bv);
    chk("R12 tick with event keeps count", bv, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule